// File: doc/BRIEF.md
# Interlocked Strobe/Acknowledge Parallel Port

This block moves bytes between an on-chip byte stream and an external device over a parallel data bus and two handshake wires. One wire is an active-low strobe that says "data is on the bus". The other is an active-high acknowledge that says "ready for the next byte". A direction input picks the roles. In receive mode the device drives the strobe and the block answers on the acknowledge line. In transmit mode the block drives the strobe and watches the acknowledge line. In both modes the wires follow a four-phase interlocked order: strobe falls, acknowledge falls, strobe rises, acknowledge rises. Each edge waits on a level of the opposite wire, not on a fixed period.

Both incoming handshake wires pass through a two-flop synchronizer before the block acts on them. Receive and transmit engines each enforce a minimum low width, counted in system clocks, on the wire they drive. In transmit mode the bus is driven a set number of clocks before the strobe falls.

The internal side is a pair of valid/ready streams. On the transmit stream a beat is accepted only while `tx_ready` is high, and `tx_ready` stays low from the accept until the device has closed the four-phase cycle. On the receive stream a captured byte stays on `rx_data` with `rx_valid` high until the consumer raises `rx_ready`. The block holds the device off (acknowledge low) for as long as the consumer applies back-pressure. A one-cycle interrupt pulse marks each capture.

Top module: `pph_port`

## Requirements
- R1: After reset the acknowledge output and the strobe output are high, `rx_valid`, `rx_irq` and `busy` are low, and in receive mode (`dir`=0) `tx_ready` and `port_oe` are low.
- R2: With `dir`=1 (transmit) `port_oe` is high and the acknowledge output stays high whatever the strobe input does. With `dir`=0 (receive) the strobe output stays high and `tx_ready` stays low. Changing `dir` returns both engines to idle and discards a byte that has not been read.
- R3: In receive mode, when the strobe input falls while idle, `port_din` is captured into `rx_data`, `rx_valid` rises and the acknowledge output falls, all on the third rising clock edge after the strobe change.
- R4: `rx_irq` is high for exactly one cycle, the cycle in which a newly captured byte first appears with `rx_valid` high.
- R5: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high, `rx_data` stays unchanged and the acknowledge output stays low.
- R6: The acknowledge output rises only when the byte has been read, the synchronized strobe is high, and the acknowledge has been low for at least LOW_CYC cycles. With `rx_ready` held high and the strobe released d cycles after the acknowledge is first seen low, the acknowledge stays low for max(LOW_CYC, d+3) cycles.
- R7: A strobe fall that arrives while the acknowledge is still low is ignored: no second byte is captured, and the first byte is delivered unchanged.
- R8: In transmit mode `tx_ready` is high only while idle. An accepted beat puts `tx_data` on `port_dout`, raises `busy`, and the strobe output falls SETUP_CYC cycles after the accepting edge.
- R9: The strobe output stays low until the synchronized acknowledge input is low and the strobe has been low for at least LOW_CYC cycles. With the acknowledge pulled low d cycles after the strobe is first seen low, the strobe stays low for max(LOW_CYC, d+3) cycles.
- R10: After the strobe rises, `busy` stays high and `tx_ready` stays low until the acknowledge input is back high. `tx_ready` returns on the third rising edge after that change.
- R11: `port_dout` does not change while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir | input | 1 | 1 = transmit to device, 0 = receive from device |
| tx_valid | input | 1 | Transmit stream: byte offered |
| tx_data | input | DATA_W | Transmit stream: byte |
| tx_ready | output | 1 | Transmit stream: block can take a byte |
| rx_valid | output | 1 | Receive stream: captured byte available |
| rx_data | output | DATA_W | Receive stream: captured byte |
| rx_ready | input | 1 | Receive stream: consumer takes the byte |
| rx_irq | output | 1 | One-cycle pulse per captured byte |
| busy | output | 1 | Transmit handshake in progress |
| port_din | input | DATA_W | Data bus as seen from the pins |
| port_dout | output | DATA_W | Data bus value driven in transmit mode |
| port_oe | output | 1 | Data bus output enable |
| ext_stb_n_i | input | 1 | Strobe from the device (receive mode) |
| ext_stb_n_o | output | 1 | Strobe to the device (transmit mode) |
| ext_ack_i | input | 1 | Acknowledge from the device (transmit mode) |
| ext_ack_o | output | 1 | Acknowledge to the device (receive mode) |

## Verification
All 256 byte values are sent through each direction. For each byte the device's response delay cycles through 0 to 4 clocks. This separates the case where the minimum low width sets the pulse length from the case where the interlock wait sets it. Two further patterns test the receive side: a consumer that holds `rx_ready` low, and a device that issues a second strobe before the acknowledge rises. Together they show that back-pressure keeps the acknowledge low and that an early strobe is ignored. A delayed acknowledge release in transmit mode shows that the strobe and stream stay locked until the last phase. Direction changes, with and without a pending byte, show that each wire is held idle in the mode that does not drive it.

// File: rtl/pph_pkg.sv
package pph_pkg;
  typedef enum logic {
    RX_IDLE,
    RX_HOLD
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SETUP,
    TX_STROBE,
    TX_DRAIN
  } tx_state_e;
endpackage

// File: rtl/pph_sync.sv
module pph_sync #(
  parameter int            W       = 2,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pph_rx.sv
module pph_rx
  import pph_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LOW_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              stb_s,
  input  logic [DATA_W-1:0] pin,
  output logic              ack_o,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              rx_irq
);
  localparam int CW = $clog2(LOW_CYC + 1);

  rx_state_e st;
  logic      stb_q;
  logic      fall;
  logic [CW-1:0] cnt;

  assign fall = stb_q & ~stb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      ack_o    <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_irq   <= 1'b0;
      cnt      <= '0;
      stb_q    <= 1'b1;
    end else begin
      stb_q  <= stb_s;
      rx_irq <= 1'b0;
      if (!en) begin
        st       <= RX_IDLE;
        ack_o    <= 1'b1;
        rx_valid <= 1'b0;
        cnt      <= '0;
      end else begin
        case (st)
          RX_IDLE: begin
            if (fall) begin
              rx_data  <= pin;
              rx_valid <= 1'b1;
              rx_irq   <= 1'b1;
              ack_o    <= 1'b0;
              cnt      <= '0;
              st       <= RX_HOLD;
            end
          end
          RX_HOLD: begin
            if (cnt < CW'(LOW_CYC)) cnt <= cnt + 1'b1;
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (cnt >= CW'(LOW_CYC - 1) && !rx_valid && stb_s) begin
              ack_o <= 1'b1;
              st    <= RX_IDLE;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && !ack_o));

  // R6
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(!en || (!rx_valid && stb_s)));

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_valid && !ack_o));
endmodule

// File: rtl/pph_tx.sv
module pph_tx
  import pph_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int LOW_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ack_s,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              stb_n_o,
  output logic [DATA_W-1:0] pout,
  output logic              busy
);
  localparam int CMAX = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  tx_state_e st;
  logic [CW-1:0] cnt;

  assign tx_ready = en && (st == TX_IDLE);
  assign busy     = (st != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      stb_n_o <= 1'b1;
      pout    <= '0;
      cnt     <= '0;
    end else if (!en) begin
      st      <= TX_IDLE;
      stb_n_o <= 1'b1;
      cnt     <= '0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (tx_valid) begin
            pout <= tx_data;
            cnt  <= '0;
            st   <= TX_SETUP;
          end
        end
        TX_SETUP: begin
          if (cnt >= CW'(SETUP_CYC - 1)) begin
            stb_n_o <= 1'b0;
            cnt     <= '0;
            st      <= TX_STROBE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_STROBE: begin
          if (cnt < CW'(LOW_CYC)) cnt <= cnt + 1'b1;
          if (cnt >= CW'(LOW_CYC - 1) && !ack_s) begin
            stb_n_o <= 1'b1;
            st      <= TX_DRAIN;
          end
        end
        TX_DRAIN: begin
          if (ack_s) st <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R9
  stb_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_n_o) |-> $past(!en || !ack_s));

  // R11
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pout));

  // R10
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_ready) && $past(en)) |-> $past(ack_s));
endmodule

// File: rtl/pph_port.sv
module pph_port
  import pph_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 2,
  parameter int LOW_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              rx_irq,
  output logic              busy,
  input  logic [DATA_W-1:0] port_din,
  output logic [DATA_W-1:0] port_dout,
  output logic              port_oe,
  input  logic              ext_stb_n_i,
  output logic              ext_stb_n_o,
  input  logic              ext_ack_i,
  output logic              ext_ack_o
);
  localparam int WCW = $clog2(LOW_CYC + 1);

  logic ack_s;
  logic stb_s;

  pph_sync #(
    .W       (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b11)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ext_ack_i, ext_stb_n_i}),
    .q     ({ack_s, stb_s})
  );

  pph_rx #(
    .DATA_W  (DATA_W),
    .LOW_CYC (LOW_CYC)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (~dir),
    .stb_s    (stb_s),
    .pin      (port_din),
    .ack_o    (ext_ack_o),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .rx_irq   (rx_irq)
  );

  pph_tx #(
    .DATA_W    (DATA_W),
    .SETUP_CYC (SETUP_CYC),
    .LOW_CYC   (LOW_CYC)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (dir),
    .ack_s    (ack_s),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .stb_n_o  (ext_stb_n_o),
    .pout     (port_dout),
    .busy     (busy)
  );

  assign port_oe = dir;

  logic [WCW-1:0] ack_lo_run;
  logic [WCW-1:0] stb_lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_lo_run <= '0;
      stb_lo_run <= '0;
    end else begin
      if (ext_ack_o) ack_lo_run <= '0;
      else if (ack_lo_run < WCW'(LOW_CYC)) ack_lo_run <= ack_lo_run + 1'b1;
      if (ext_stb_n_o) stb_lo_run <= '0;
      else if (stb_lo_run < WCW'(LOW_CYC)) stb_lo_run <= stb_lo_run + 1'b1;
    end
  end

  // R6
  ack_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ext_ack_o) && $past(!dir)) |-> (ack_lo_run >= WCW'(LOW_CYC)));

  // R9
  stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ext_stb_n_o) && $past(dir)) |-> (stb_lo_run >= WCW'(LOW_CYC)));

  // R2
  rx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir && $past(!dir)) |-> (ext_stb_n_o && !tx_ready));

  // R2
  tx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && $past(dir)) |-> (ext_ack_o && !rx_valid));
endmodule

// File: tb/tb_pph_port.sv
module tb_pph_port;
  localparam int DW    = 8;
  localparam int SETUP = 2;
  localparam int LOW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir = 1'b0;
  logic tx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic tx_ready;
  logic rx_valid;
  logic [DW-1:0] rx_data;
  logic rx_ready = 1'b1;
  logic rx_irq;
  logic busy;
  logic [DW-1:0] port_din = '0;
  logic [DW-1:0] port_dout;
  logic port_oe;
  logic ext_stb_n_i = 1'b1;
  logic ext_stb_n_o;
  logic ext_ack_i = 1'b1;
  logic ext_ack_o;

  pph_port #(.DATA_W(DW), .SETUP_CYC(SETUP), .LOW_CYC(LOW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .dir(dir),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .rx_irq(rx_irq),
    .busy(busy), .port_din(port_din), .port_dout(port_dout), .port_oe(port_oe),
    .ext_stb_n_i(ext_stb_n_i), .ext_stb_n_o(ext_stb_n_o),
    .ext_ack_i(ext_ack_i), .ext_ack_o(ext_ack_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // receive one byte; device releases strobe d cycles after seeing the acknowledge low
  task automatic rx_xfer(input logic [DW-1:0] b, input int d);
    int k;
    int w;
    @(negedge clk);
    port_din = b;
    ext_stb_n_i = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (ext_ack_o && k < 50);
    chk(k == 3, "R3 ack latency", k, 3);
    chk(rx_valid && rx_data == b, "R3 captured byte", int'(rx_data), int'(b));
    chk(rx_irq == 1'b1, "R4 irq on capture", int'(rx_irq), 1);
    w = 1;
    k = 0;
    while (1) begin
      if (k == d) ext_stb_n_i = 1'b1;
      @(negedge clk);
      k++;
      if (k == 1) chk(rx_irq == 1'b0, "R4 irq single cycle", int'(rx_irq), 0);
      if (ext_ack_o || w > 60) break;
      w++;
    end
    chk(w == imax(LOW, d + 3), "R6 ack low width", w, imax(LOW, d + 3));
    chk(!rx_valid, "R6 byte consumed", int'(rx_valid), 0);
  endtask

  // send one byte; device pulls acknowledge low d cycles after seeing the strobe, releases it e cycles after strobe rises
  task automatic tx_xfer(input logic [DW-1:0] b, input int d, input int e);
    int k;
    int w;
    @(negedge clk);
    tx_data = b;
    tx_valid = 1'b1;
    k = 0;
    while (!tx_ready && k < 50) begin @(negedge clk); k++; end
    @(negedge clk);
    tx_valid = 1'b0;
    chk(busy && !tx_ready, "R8 busy after accept", int'(busy), 1);
    k = 0;
    while (ext_stb_n_o && k < 50) begin k++; @(negedge clk); end
    chk(k == SETUP, "R8 setup delay", k, SETUP);
    chk(port_dout == b, "R8 driven byte", int'(port_dout), int'(b));
    w = 1;
    k = 0;
    while (1) begin
      if (k == d) ext_ack_i = 1'b0;
      @(negedge clk);
      k++;
      chk(port_dout == b, "R11 bus stable", int'(port_dout), int'(b));
      if (ext_stb_n_o || w > 60) break;
      w++;
    end
    chk(w == imax(LOW, d + 3), "R9 strobe low width", w, imax(LOW, d + 3));
    for (int i = 0; i < e; i++) begin
      @(negedge clk);
      chk(busy && !tx_ready && ext_stb_n_o, "R10 locked until ack high", int'(tx_ready), 0);
    end
    ext_ack_i = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!tx_ready && k < 50);
    chk(k == 3, "R10 ready latency", k, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ext_ack_o && ext_stb_n_o, "R1 handshake idle", int'({ext_ack_o, ext_stb_n_o}), 3);
    chk(!rx_valid && !rx_irq && !busy, "R1 flags clear", int'({rx_valid, rx_irq, busy}), 0);
    chk(!tx_ready && !port_oe, "R1 receive mode", int'({tx_ready, port_oe}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: receive mode ignores the transmit stream
    tx_valid = 1'b1;
    tx_data = 8'h3C;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!tx_ready && ext_stb_n_o && !port_oe, "R2 tx idle in receive", int'(tx_ready), 0);
    end
    tx_valid = 1'b0;

    // R2: transmit mode ignores the incoming strobe
    dir = 1'b1;
    @(negedge clk);
    ext_stb_n_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(ext_ack_o && !rx_valid && port_oe, "R2 rx idle in transmit", int'(ext_ack_o), 1);
    end
    ext_stb_n_i = 1'b1;
    repeat (4) @(negedge clk);
    dir = 1'b0;
    repeat (4) @(negedge clk);

    // byte sweep, receive
    for (int b = 0; b < 256; b++) rx_xfer(DW'(b), b % 5);

    // R5 / R7: back-pressure and early strobe
    rx_ready = 1'b0;
    @(negedge clk);
    port_din = 8'hA5;
    ext_stb_n_i = 1'b0;
    repeat (5) @(negedge clk);
    ext_stb_n_i = 1'b1;
    repeat (4) @(negedge clk);
    port_din = 8'h5A;
    ext_stb_n_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!ext_ack_o && rx_valid && rx_data == 8'hA5, "R5 held under back-pressure", int'(rx_data), 8'hA5);
    end
    rx_ready = 1'b1;
    @(negedge clk);
    chk(!rx_valid, "R5 byte taken", int'(rx_valid), 0);
    repeat (6) @(negedge clk);
    chk(!ext_ack_o && !rx_valid, "R7 early strobe ignored", int'(rx_valid), 0);
    ext_stb_n_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(ext_ack_o && !rx_valid, "R7 no second capture", int'(rx_valid), 0);

    // R2: direction change drops a pending byte
    rx_ready = 1'b0;
    rx_xfer_start: begin
      @(negedge clk);
      port_din = 8'hC3;
      ext_stb_n_i = 1'b0;
      repeat (4) @(negedge clk);
      chk(rx_valid && rx_data == 8'hC3, "R3 pending byte", int'(rx_data), 8'hC3);
    end
    dir = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rx_valid && ext_ack_o, "R2 pending byte dropped", int'(rx_valid), 0);
    ext_stb_n_i = 1'b1;
    rx_ready = 1'b1;
    repeat (4) @(negedge clk);

    // byte sweep, transmit
    for (int b = 0; b < 256; b++) tx_xfer(DW'(b), (b * 3) % 5, b % 4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule